// File: doc/BRIEF.md
# Half-Flash ADC Conversion Sequencer

This block is the host-side sequencer for a parallel 8-bit half-flash analog-to-digital converter used in its write-then-read mode. Internal logic hands it a channel number through a valid/ready handshake. The sequencer drops the converter's chip select and presents the channel address. It then pulses the write strobe to start a conversion, pulses the read strobe to fetch the result, and returns the byte with a one-cycle valid pulse.

Each request chooses one of two read policies. In the wait policy the sequencer holds off the read strobe until the converter's active-low end-of-conversion line, seen through a two-flop synchronizer, reports completion. A timeout ends the cycle with an error pulse if that line never falls. In the early policy the read strobe falls a fixed number of cycles after write rises and does not wait for the line at all. This cuts the conversion short. Between conversions the sequencer keeps the next write falling edge back until a minimum acquisition interval has passed since the end-of-conversion line last fell.

Every pulse width, setup count, hold count, acquisition interval and timeout is a parameter in system-clock cycles. The defaults give a 660 ns early-read cycle at 100 MHz: 20 cycles of write, 6 cycles from write to read, and 40 cycles of read access.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, adc_cs_n, adc_wr_n and adc_rd_n are high, req_ready is high, and smp_valid and smp_err are low.
- R2: req_ready is high only while the sequencer is idle with chip select high. A request is taken when req_valid and req_ready are both high. Each accepted request produces exactly one write pulse, and a request held high during a busy cycle starts nothing extra.
- R3: adc_addr carries the accepted req_chan and does not change while adc_cs_n is low. adc_cs_n is low for at least CSS_CYC cycles with both strobes high before adc_wr_n falls.
- R4: adc_wr_n is low for exactly WR_CYC cycles per conversion, and only while adc_cs_n is low.
- R5: With req_early = 1, adc_rd_n falls exactly RDLY_CYC cycles after adc_wr_n rises, whatever the state of adc_int_n.
- R6: With req_early = 0, adc_rd_n falls only after adc_int_n has gone low and has passed the two-flop synchronizer.
- R7: adc_rd_n is low for exactly ACC_CYC cycles. smp_valid is high for one cycle, in the cycle in which adc_rd_n returns high, and smp_data then holds the value of adc_data in the last read cycle.
- R8: After adc_rd_n rises, adc_cs_n stays low for exactly CSH_CYC cycles and then rises together with req_ready.
- R9: adc_wr_n never falls earlier than ACQ_CYC cycles after the most recent falling edge of adc_int_n.
- R10: With req_early = 0, if adc_int_n stays high for TMO_CYC cycles after adc_wr_n rises, smp_err pulses for one cycle. In that conversion smp_valid stays low, adc_rd_n stays high and chip select is then released.
- R11: adc_wr_n and adc_rd_n are never low in the same cycle, and adc_rd_n is low only while adc_cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Conversion request |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_chan | input | ADDR_W | Analog channel for the request |
| req_early | input | 1 | 1 = early read, 0 = wait for end of conversion |
| smp_valid | output | 1 | One-cycle pulse: smp_data holds a result |
| smp_data | output | DATA_W | Conversion result |
| smp_err | output | 1 | One-cycle pulse: end of conversion timed out |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_wr_n | output | 1 | Converter start strobe, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_addr | output | ADDR_W | Converter channel address |
| adc_int_n | input | 1 | Converter end-of-conversion, active low, asynchronous |
| adc_data | input | DATA_W | Converter output bus |

## Verification
The bound checker watches the strobe relationships on every cycle. It checks that write and read never overlap and that both sit inside chip select. It checks that the address does not move during a select window, that the write and read widths are exact, that ready is given only when all strobes are released, and that the valid and error pulses last one cycle and never coincide. Other behaviour depends on a converter that answers, so only the bench scenarios can show it. That covers the data path with the converter's byte, the choice between the early and the wait read policies, the acquisition spacing after a real end-of-conversion edge, the timeout when the converter stays silent, and a request held high during a busy cycle. The bench sweeps all eight channels under both policies back to back, so the acquisition guard sets the pace.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WRITE,
        ST_GAP,
        ST_WAITI,
        ST_READ,
        ST_HOLD
    } seq_state_e;

    function automatic int max_of6(input int a, input int b, input int c,
                                   input int d, input int e, input int f);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        if (f > m) m = f;
        return m;
    endfunction

endpackage

// File: rtl/adc_sync2.sv
module adc_sync2 #(
    parameter int  STAGES    = 2,
    parameter bit  RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/adc_acq_guard.sv
module adc_acq_guard #(
    parameter int ACQ_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_n_s,
    output logic acq_ok
);
    localparam int AW = $clog2(ACQ_CYC + 1);

    typedef struct packed {
        logic          prev;
        logic [AW-1:0] cnt;
    } guard_t;

    guard_t g_d, g_q;
    logic   fall;

    always_comb begin
        g_d      = g_q;
        fall     = g_q.prev && !int_n_s;
        g_d.prev = int_n_s;
        if (fall)                 g_d.cnt = AW'(ACQ_CYC);
        else if (g_q.cnt != '0)   g_d.cnt = g_q.cnt - AW'(1);
        acq_ok   = (g_q.cnt == '0) && !fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{prev: 1'b1, cnt: '0};
        else        g_q <= g_d;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int WR_CYC   = 20,
    parameter int RDLY_CYC = 6,
    parameter int ACC_CYC  = 40,
    parameter int CSS_CYC  = 2,
    parameter int CSH_CYC  = 2,
    parameter int ACQ_CYC  = 40,
    parameter int TMO_CYC  = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_chan,
    input  logic              req_early,
    output logic              smp_valid,
    output logic [DATA_W-1:0] smp_data,
    output logic              smp_err,
    output logic              adc_cs_n,
    output logic              adc_wr_n,
    output logic              adc_rd_n,
    output logic [ADDR_W-1:0] adc_addr,
    input  logic              adc_int_n,
    input  logic [DATA_W-1:0] adc_data
);
    localparam int CNT_MAX = max_of6(WR_CYC, RDLY_CYC, ACC_CYC, CSS_CYC, CSH_CYC, TMO_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              early;
        logic              cs_n;
        logic              wr_n;
        logic              rd_n;
        logic              ready;
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] data;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      int_n_s;
    logic      acq_ok;

    adc_sync2 #(.STAGES(2), .RESET_VAL(1'b1)) u_int_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (adc_int_n),
        .q     (int_n_s)
    );

    adc_acq_guard #(.ACQ_CYC(ACQ_CYC)) u_acq_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .int_n_s (int_n_s),
        .acq_ok  (acq_ok)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.err   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_SETUP;
                    r_d.addr  = req_chan;
                    r_d.early = req_early;
                    r_d.cnt   = CNT_W'(CSS_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else if (acq_ok) begin
                    r_d.st  = ST_WRITE;
                    r_d.cnt = CNT_W'(WR_CYC - 1);
                end
            end
            ST_WRITE: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else if (r_q.early) begin
                    r_d.st  = ST_GAP;
                    r_d.cnt = CNT_W'(RDLY_CYC - 1);
                end else begin
                    r_d.st  = ST_WAITI;
                    r_d.cnt = CNT_W'(TMO_CYC - 1);
                end
            end
            ST_GAP: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else begin
                    r_d.st  = ST_READ;
                    r_d.cnt = CNT_W'(ACC_CYC - 1);
                end
            end
            ST_WAITI: begin
                if (!int_n_s) begin
                    r_d.st  = ST_READ;
                    r_d.cnt = CNT_W'(ACC_CYC - 1);
                end else if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_HOLD;
                    r_d.cnt = CNT_W'(CSH_CYC - 1);
                end
            end
            ST_READ: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else begin
                    r_d.data  = adc_data;
                    r_d.valid = 1'b1;
                    r_d.st    = ST_HOLD;
                    r_d.cnt   = CNT_W'(CSH_CYC - 1);
                end
            end
            ST_HOLD: begin
                if (r_q.cnt != '0) r_d.cnt = r_q.cnt - CNT_W'(1);
                else               r_d.st  = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.cs_n  = (r_d.st == ST_IDLE);
        r_d.ready = (r_d.st == ST_IDLE);
        r_d.wr_n  = (r_d.st != ST_WRITE);
        r_d.rd_n  = (r_d.st != ST_READ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.cs_n  <= 1'b1;
            r_q.wr_n  <= 1'b1;
            r_q.rd_n  <= 1'b1;
            r_q.ready <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = r_q.ready;
    assign smp_valid = r_q.valid;
    assign smp_data  = r_q.data;
    assign smp_err   = r_q.err;
    assign adc_cs_n  = r_q.cs_n;
    assign adc_wr_n  = r_q.wr_n;
    assign adc_rd_n  = r_q.rd_n;
    assign adc_addr  = r_q.addr;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int ADDR_W  = 3,
    parameter int WR_CYC  = 20,
    parameter int ACC_CYC = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              smp_valid,
    input logic              smp_err,
    input logic              adc_cs_n,
    input logic              adc_wr_n,
    input logic              adc_rd_n,
    input logic [ADDR_W-1:0] adc_addr
);
    logic [15:0] wr_lo_q, rd_lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_lo_q <= '0;
            rd_lo_q <= '0;
        end else begin
            wr_lo_q <= adc_wr_n ? 16'd0 : wr_lo_q + 16'd1;
            rd_lo_q <= adc_rd_n ? 16'd0 : rd_lo_q + 16'd1;
        end
    end

    a_r4_wr_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_wr_n |-> !adc_cs_n);

    a_r11_rd_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> !adc_cs_n);

    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_wr_n |-> adc_rd_n);

    a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (adc_cs_n && adc_wr_n && adc_rd_n));

    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && $past(!adc_cs_n)) |-> $stable(adc_addr));

    a_r4_wr_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_wr_n) |-> (wr_lo_q == 16'(WR_CYC)));

    a_r7_rd_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_rd_n) |-> (rd_lo_q == 16'(ACC_CYC)));

    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    a_r7_valid_at_rd_rise: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $rose(adc_rd_n));

    a_r10_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        smp_err |-> (!smp_valid && adc_rd_n));

    a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        smp_err |=> !smp_err);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .WR_CYC  (WR_CYC),
    .ACC_CYC (ACC_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .smp_valid (smp_valid),
    .smp_err   (smp_err),
    .adc_cs_n  (adc_cs_n),
    .adc_wr_n  (adc_wr_n),
    .adc_rd_n  (adc_rd_n),
    .adc_addr  (adc_addr)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    localparam int WR   = 3;
    localparam int RDLY = 2;
    localparam int ACC  = 4;
    localparam int CSS  = 1;
    localparam int CSH  = 1;
    localparam int ACQ  = 12;
    localparam int TMO  = 30;
    localparam int TINTL = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_chan = '0;
    logic       req_early = 1'b0;
    logic       smp_valid;
    logic [7:0] smp_data;
    logic       smp_err;
    logic       adc_cs_n, adc_wr_n, adc_rd_n;
    logic [2:0] adc_addr;
    logic       adc_int_n = 1'b1;
    logic [7:0] adc_data = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_seq_ctrl #(
        .ADDR_W(3), .DATA_W(8), .WR_CYC(WR), .RDLY_CYC(RDLY), .ACC_CYC(ACC),
        .CSS_CYC(CSS), .CSH_CYC(CSH), .ACQ_CYC(ACQ), .TMO_CYC(TMO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_early(req_early), .smp_valid(smp_valid),
        .smp_data(smp_data), .smp_err(smp_err), .adc_cs_n(adc_cs_n),
        .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n), .adc_addr(adc_addr),
        .adc_int_n(adc_int_n), .adc_data(adc_data)
    );

    // converter model
    bit       m_en = 1'b1;
    bit       m_pend = 1'b0;
    int       m_tcnt = 0;
    int       m_seq = 0;
    logic [7:0] m_val = '0;
    logic     m_pwr = 1'b1, m_prd = 1'b1, m_pcs = 1'b1;

    always @(negedge clk) begin
        if ((adc_rd_n && !m_prd) || (adc_cs_n && !m_pcs)) adc_int_n <= 1'b1;
        if (m_pend) begin
            if (!adc_rd_n || m_tcnt <= 1) begin
                adc_int_n <= 1'b0;
                m_pend = 1'b0;
            end else begin
                m_tcnt--;
            end
        end
        if (!adc_wr_n && m_pwr) begin
            m_val = {adc_addr, 5'(m_seq)} ^ 8'h5A;
            m_seq++;
        end
        if (adc_wr_n && !m_pwr && m_en) begin
            m_pend = 1'b1;
            m_tcnt = TINTL;
        end
        adc_data <= adc_rd_n ? 8'h00 : m_val;
        m_pwr = adc_wr_n;
        m_prd = adc_rd_n;
        m_pcs = adc_cs_n;
    end

    // monitor
    int cyc = 0;
    int wr_w = 0, rd_w = 0, last_wr_w = 0, last_rd_w = 0;
    int since_wr = 0, last_wr2rd = 0;
    int pre = 0, last_pre = 0, post = 0, last_post = 0;
    bit in_pre = 1'b0, rd_done = 1'b0;
    int wr_falls = 0, rd_falls = 0, addr_bad = 0, busy_ready = 0;
    int int_fall_cyc = 0, last_gap = 0;
    bit have_fall = 1'b0, gap_valid = 1'b0;
    logic int_at_rd = 1'b1;
    logic [2:0] exp_addr = '0;
    logic p_wr = 1'b1, p_rd = 1'b1, p_cs = 1'b1, p_int = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            since_wr++;
            if (!adc_int_n && p_int) begin int_fall_cyc = cyc; have_fall = 1'b1; end
            if (!adc_cs_n && p_cs) begin pre = 0; in_pre = 1'b1; end
            if (in_pre && !adc_cs_n && adc_wr_n) pre++;
            if (!adc_wr_n) begin
                if (p_wr) begin
                    wr_falls++;
                    last_pre = pre;
                    in_pre = 1'b0;
                    if (have_fall) begin last_gap = cyc - int_fall_cyc; gap_valid = 1'b1; end
                end
                wr_w++;
                if (adc_addr != exp_addr) addr_bad++;
            end else if (!p_wr) begin
                last_wr_w = wr_w; wr_w = 0; since_wr = 0;
            end
            if (!adc_rd_n) begin
                if (p_rd) begin rd_falls++; last_wr2rd = since_wr; int_at_rd = adc_int_n; end
                rd_w++;
            end else if (!p_rd) begin
                last_rd_w = rd_w; rd_w = 0; rd_done = 1'b1;
            end
            if (rd_done && !adc_cs_n) post++;
            if (adc_cs_n && !p_cs) begin last_post = post; post = 0; rd_done = 1'b0; end
            if (!adc_cs_n && req_ready) busy_ready++;
            p_wr = adc_wr_n; p_rd = adc_rd_n; p_cs = adc_cs_n; p_int = adc_int_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    int seq = 0;

    task automatic run_conv(input int ch, input bit early, input bit expect_to, input bit hold_valid);
        int wf0, rf0, ab0, n;
        logic gv, ge;
        logic [7:0] gd, expd;
        wf0 = wr_falls; rf0 = rd_falls; ab0 = addr_bad;
        m_en = !expect_to;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_addr  = 3'(ch);
        req_chan  = 3'(ch);
        req_early = early;
        req_valid = 1'b1;
        if (!hold_valid) begin @(negedge clk); req_valid = 1'b0; end
        n = 0;
        while (n < 400 && !(smp_valid || smp_err)) begin @(negedge clk); n++; end
        req_valid = 1'b0;
        gv = smp_valid; ge = smp_err; gd = smp_data;
        n = 0;
        while (n < 100 && !adc_cs_n) begin @(negedge clk); n++; end
        @(negedge clk);
        expd = {3'(ch), 5'(seq)} ^ 8'h5A;
        seq++;
        chk(wr_falls - wf0 == 1, "R2 one write per request", wr_falls - wf0, 1);
        chk(addr_bad == ab0, "R3 address during write", addr_bad - ab0, 0);
        chk(last_pre >= CSS, "R3 select setup", last_pre, CSS);
        chk(last_wr_w == WR, "R4 write width", last_wr_w, WR);
        chk(adc_cs_n == 1'b1, "R8 select released", int'(adc_cs_n), 1);
        if (gap_valid)
            chk(last_gap >= ACQ, "R9 acquisition gap", last_gap, ACQ);
        if (expect_to) begin
            chk(ge == 1'b1 && gv == 1'b0, "R10 timeout error", {ge, gv}, 2);
            chk(rd_falls == rf0, "R10 no read on timeout", rd_falls - rf0, 0);
        end else begin
            chk(gv == 1'b1 && ge == 1'b0, "R7 valid pulse", {gv, ge}, 2);
            chk(gd == expd, "R7 sample data", gd, expd);
            chk(last_rd_w == ACC, "R7 read width", last_rd_w, ACC);
            chk(last_post == CSH, "R8 select hold", last_post, CSH);
            if (early) begin
                chk(last_wr2rd == RDLY, "R5 early read delay", last_wr2rd, RDLY);
                chk(int_at_rd == 1'b1, "R5 read before interrupt", int'(int_at_rd), 1);
            end else begin
                chk(int_at_rd == 1'b0, "R6 read after interrupt", int'(int_at_rd), 0);
                chk(last_wr2rd >= TINTL + 2, "R6 sync latency", last_wr2rd, TINTL + 2);
            end
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(adc_cs_n && adc_wr_n && adc_rd_n, "R1 strobes high in reset",
            {adc_cs_n, adc_wr_n, adc_rd_n}, 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(!smp_valid && !smp_err, "R1 no pulses after reset", {smp_valid, smp_err}, 0);
        for (int pol = 1; pol >= 0; pol--)
            for (int ch = 0; ch < 8; ch++)
                run_conv(ch, pol[0], 1'b0, 1'b0);
        run_conv(6, 1'b0, 1'b1, 1'b0);
        run_conv(2, 1'b1, 1'b0, 1'b0);
        run_conv(5, 1'b0, 1'b0, 1'b1);
        run_conv(3, 1'b1, 1'b0, 1'b1);
        chk(busy_ready == 0, "R2 ready low while busy", busy_ready, 0);
        chk(rd_falls == 19, "R11 read count", rd_falls, 19);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule